// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt request inputs and presents them to a processor on two lines: a normal request line, arbitrated by an 8-level priority resolver, and a fast request line. Each source has a configuration word and a 32-bit vector word, both written over a simple single-cycle register bus. Each source can be level-sensitive (high or low) or edge-sensitive (rising or falling). An edge is latched until software or an acknowledge removes it.

Service follows a claim and finish protocol. The handler reads the claim register, which returns the vector of the best qualified source. The same read records that source's priority on an internal nesting stack, drops the latched edge of that source, and lowers the normal line. Until the matching end-of-service write, only strictly higher priorities can raise the line again. Source 0 always feeds the fast line. Any other source can be steered to the fast line through the fast-steering set.

Top module: `vec_intc`

## Requirements
- R1: After reset the normal and fast lines are low, the enable set and fast-steering set read as zero, and the servicing register reads zero.
- R2: In the configuration word, bits 2:0 hold the priority (7 is highest) and bits 6:5 hold the trigger: 00 level-low, 01 falling edge, 10 level-high, 11 rising edge. A level source is pending while its input is at the active level. The pending word (offset 0x128) shows this state.
- R3: An edge source becomes pending on its selected edge and stays pending after the input returns.
- R4: The normal line is raised only for enabled, pending sources. Among those sharing the highest priority, the lowest source number wins. Writing a one to enable-set (0x110) or enable-clear (0x114) enables or disables that source.
- R5: Reading the claim register (0x100) with a qualified winner returns that source's vector word (offset 0x080 + 4·n). The read pushes the winner's priority and number, and the normal line falls if nothing higher is pending. The servicing register (0x134) then shows bit 31 set and the source number in bits 4:0.
- R6: While the stack holds a level, a pending source raises the normal line only if its priority is strictly greater than the top entry. A claim in that state nests one level deeper.
- R7: A claim read when no source qualifies returns the spurious vector word (0x108) and leaves the stack unchanged.
- R8: Writing the end-of-service register (0x10C) pops one stack entry. This exposes the previous level, or an empty stack, and this can re-raise the normal line.
- R9: A claim removes the latched edge of the winning edge source, so the source does not re-raise the line after end-of-service.
- R10: Writing a one to pending-set (0x118) latches a source pending. Writing a one to pending-clear (0x11C) drops a latched pending state.
- R11: Source 0, when enabled and pending, drives only the fast line and never wins normal arbitration. The fast vector register (0x104) returns source 0's vector word.
- R12: Writing a one to fast-set (0x120) steers a source above 0 to the fast line and removes it from normal arbitration. Fast-clear (0x124) returns it to normal arbitration, and the fast-steering set is read at 0x130.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt request inputs, one per source |
| bus_wr_i | input | 1 | Register write strobe, one cycle |
| bus_rd_i | input | 1 | Register read strobe, one cycle (side effects on the claim and fast vector registers) |
| bus_addr_i | input | 10 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during the read strobe |
| irq_o | output | 1 | Normal interrupt request line, active high |
| fiq_o | output | 1 | Fast interrupt request line, active high |

## Verification
The priority resolver is tried with three patterns: two sources of equal priority plus a lower one, a lower-priority claim followed by a higher arrival, and an empty or fully blocked request set. Together these separate the tie-break order, strict-greater nesting and the spurious path. Level-high, level-low, rising and falling triggers are each driven and then released, which shows a latched edge apart from a followed level. The same edge source is then claimed, finished and forced pending again through the command registers. Source 0 and a steered source are checked on both lines, so that a fast path leaking into normal arbitration is caught.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  // trigger encodings, bit 0 set means edge-sensitive
  localparam logic [1:0] TRG_LVL_LO = 2'b00;
  localparam logic [1:0] TRG_FALL   = 2'b01;
  localparam logic [1:0] TRG_LVL_HI = 2'b10;
  localparam logic [1:0] TRG_RISE   = 2'b11;

  // word indices inside the control area (byte offset 0x100 + 4*index)
  localparam logic [4:0] RG_CLAIM   = 5'd0;
  localparam logic [4:0] RG_FASTVEC = 5'd1;
  localparam logic [4:0] RG_SPUR    = 5'd2;
  localparam logic [4:0] RG_EOI     = 5'd3;
  localparam logic [4:0] RG_ENSET   = 5'd4;
  localparam logic [4:0] RG_ENCLR   = 5'd5;
  localparam logic [4:0] RG_PSET    = 5'd6;
  localparam logic [4:0] RG_PCLR    = 5'd7;
  localparam logic [4:0] RG_FFSET   = 5'd8;
  localparam logic [4:0] RG_FFCLR   = 5'd9;
  localparam logic [4:0] RG_PEND    = 5'd10;
  localparam logic [4:0] RG_ENAB    = 5'd11;
  localparam logic [4:0] RG_FFST    = 5'd12;
  localparam logic [4:0] RG_SERV    = 5'd13;

  localparam logic [2:0] AREA_CFG = 3'd0;
  localparam logic [2:0] AREA_VEC = 3'd1;
  localparam logic [2:0] AREA_CTL = 3'd2;
endpackage

// File: rtl/vec_intc_src_stage.sv
module vec_intc_src_stage #(
  parameter int N_SRC = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SRC-1:0]      src_i,
  input  logic [N_SRC-1:0][1:0] trig_i,
  input  logic [N_SRC-1:0]      set_i,
  input  logic [N_SRC-1:0]      clr_i,
  input  logic [N_SRC-1:0]      ack_clr_i,
  output logic [N_SRC-1:0]      pend_o
);
  import vec_intc_pkg::*;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic smp_q, prv_q, mem_q;
    logic edge_hit, lvl_act, mem_nxt;

    always_comb begin
      edge_hit = 1'b0;
      lvl_act  = 1'b0;
      unique case (trig_i[g])
        TRG_RISE:   edge_hit = smp_q & ~prv_q;
        TRG_FALL:   edge_hit = ~smp_q & prv_q;
        TRG_LVL_HI: lvl_act  = smp_q;
        default:    lvl_act  = ~smp_q;
      endcase
      mem_nxt   = (mem_q & ~clr_i[g] & ~ack_clr_i[g]) | set_i[g] | edge_hit;
      pend_o[g] = lvl_act | mem_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b0;
        prv_q <= 1'b0;
        mem_q <= 1'b0;
      end else begin
        smp_q <= src_i[g];
        prv_q <= smp_q;
        mem_q <= mem_nxt;
      end
    end
  end
endmodule

// File: rtl/vec_intc_resolver.sv
module vec_intc_resolver #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_vld_o,
  output logic [IW-1:0]                win_id_o,
  output logic [PRIO_W-1:0]            win_prio_o
);
  always_comb begin
    win_vld_o  = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    // strict compare keeps the lowest index among equal priorities
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!win_vld_o || prio_i[i] > win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_id_o   = IW'(i);
        win_prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vec_intc_stack.sv
module vec_intc_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int IW     = 5,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [IW-1:0]     push_id_i,
  output logic [DW-1:0]     depth_o,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [IW-1:0]     top_id_o
);
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [IW-1:0]     id_q   [DEPTH];
  logic [DW-1:0]     cnt_q, cnt_nxt;
  logic              do_push, do_pop;
  logic [AW-1:0]     wr_idx, top_idx;

  always_comb begin
    do_push = push_i && (cnt_q < DW'(DEPTH));
    do_pop  = pop_i && !push_i && (cnt_q != '0);
    cnt_nxt = cnt_q;
    if (do_push)     cnt_nxt = cnt_q + 1'b1;
    else if (do_pop) cnt_nxt = cnt_q - 1'b1;
    wr_idx  = AW'(cnt_q);
    top_idx = AW'(cnt_q - 1'b1);
    empty_o = (cnt_q == '0);
    top_prio_o = empty_o ? '0 : prio_q[top_idx];
    top_id_o   = empty_o ? '0 : id_q[top_idx];
    depth_o    = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        id_q[i]   <= '0;
      end
    end else begin
      cnt_q <= cnt_nxt;
      if (do_push) begin
        prio_q[wr_idx] <= push_prio_i;
        id_q[wr_idx]   <= push_id_i;
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import vec_intc_pkg::*;

  localparam int IW        = $clog2(N_SRC);
  localparam int STK_DEPTH = 1 << PRIO_W;
  localparam int DW        = $clog2(STK_DEPTH + 1);
  localparam logic [N_SRC-1:0] NORM_MASK = {{(N_SRC-1){1'b1}}, 1'b0};

  logic [N_SRC-1:0][PRIO_W-1:0] cfg_prio;
  logic [N_SRC-1:0][1:0]        cfg_trig;
  logic [DATA_W-1:0]            vec_tab [N_SRC];
  logic [DATA_W-1:0]            spur_vec;
  logic [N_SRC-1:0]             en_r, ff_r;

  logic [2:0]  area;
  logic [4:0]  rsel;
  logic [IW-1:0] idx;
  logic [1:0]  unused_addr_lsb;
  logic        ctl_wr, ctl_rd, claim_rd, fast_rd, push, pop;
  logic [N_SRC-1:0] pend, cand, set_cmd, clr_cmd, ack_clr;
  logic        win_vld, qualify, stk_empty;
  logic [IW-1:0]     win_id, top_id;
  logic [PRIO_W-1:0] win_prio, top_prio;
  logic [DW-1:0]     stk_depth;

  assign area            = bus_addr_i[9:7];
  assign rsel            = bus_addr_i[6:2];
  assign idx             = bus_addr_i[2 +: IW];
  assign unused_addr_lsb = bus_addr_i[1:0];

  always_comb begin
    ctl_wr   = bus_wr_i && area == AREA_CTL;
    ctl_rd   = bus_rd_i && area == AREA_CTL;
    claim_rd = ctl_rd && rsel == RG_CLAIM;
    fast_rd  = ctl_rd && rsel == RG_FASTVEC;
    pop      = ctl_wr && rsel == RG_EOI;
    set_cmd  = (ctl_wr && rsel == RG_PSET) ? bus_wdata_i[N_SRC-1:0] : '0;
    clr_cmd  = (ctl_wr && rsel == RG_PCLR) ? bus_wdata_i[N_SRC-1:0] : '0;
    cand     = pend & en_r & ~ff_r & NORM_MASK;
    qualify  = win_vld && (stk_empty || win_prio > top_prio);
    push     = claim_rd && qualify;
    ack_clr  = '0;
    if (push && cfg_trig[win_id][0]) ack_clr[win_id] = 1'b1;
    if (fast_rd && cfg_trig[0][0])   ack_clr[0] = 1'b1;
    irq_o    = qualify;
    fiq_o    = (pend[0] & en_r[0]) | (|(pend & en_r & ff_r & NORM_MASK));
  end

  vec_intc_src_stage #(.N_SRC(N_SRC)) u_stage (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .trig_i(cfg_trig),
    .set_i(set_cmd), .clr_i(clr_cmd), .ack_clr_i(ack_clr), .pend_o(pend)
  );

  vec_intc_resolver #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_res (
    .cand_i(cand), .prio_i(cfg_prio),
    .win_vld_o(win_vld), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  vec_intc_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W), .IW(IW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .push_prio_i(win_prio), .push_id_i(win_id),
    .depth_o(stk_depth), .empty_o(stk_empty),
    .top_prio_o(top_prio), .top_id_o(top_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_prio <= '0;
      cfg_trig <= '0;
      spur_vec <= '0;
      en_r     <= '0;
      ff_r     <= '0;
      for (int i = 0; i < N_SRC; i++) vec_tab[i] <= '0;
    end else if (bus_wr_i) begin
      if (area == AREA_CFG) begin
        cfg_prio[idx] <= bus_wdata_i[PRIO_W-1:0];
        cfg_trig[idx] <= bus_wdata_i[6:5];
      end
      if (area == AREA_VEC) vec_tab[idx] <= bus_wdata_i;
      if (ctl_wr && rsel == RG_SPUR)  spur_vec <= bus_wdata_i;
      if (ctl_wr && rsel == RG_ENSET) en_r <= en_r | bus_wdata_i[N_SRC-1:0];
      if (ctl_wr && rsel == RG_ENCLR) en_r <= en_r & ~bus_wdata_i[N_SRC-1:0];
      if (ctl_wr && rsel == RG_FFSET) ff_r <= (ff_r | bus_wdata_i[N_SRC-1:0]) & NORM_MASK;
      if (ctl_wr && rsel == RG_FFCLR) ff_r <= ff_r & ~bus_wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (area == AREA_CFG) begin
      bus_rdata_o[PRIO_W-1:0] = cfg_prio[idx];
      bus_rdata_o[6:5]        = cfg_trig[idx];
    end else if (area == AREA_VEC) begin
      bus_rdata_o = vec_tab[idx];
    end else if (area == AREA_CTL) begin
      unique case (rsel)
        RG_CLAIM:   bus_rdata_o = qualify ? vec_tab[win_id] : spur_vec;
        RG_FASTVEC: bus_rdata_o = vec_tab[0];
        RG_SPUR:    bus_rdata_o = spur_vec;
        RG_PEND:    bus_rdata_o[N_SRC-1:0] = pend;
        RG_ENAB:    bus_rdata_o[N_SRC-1:0] = en_r;
        RG_FFST:    bus_rdata_o[N_SRC-1:0] = ff_r;
        RG_SERV: begin
          bus_rdata_o[DATA_W-1] = !stk_empty;
          bus_rdata_o[IW-1:0]   = top_id;
        end
        default:    bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 3,
  localparam int IW        = $clog2(N_SRC),
  localparam int STK_DEPTH = 1 << PRIO_W,
  localparam int DW        = $clog2(STK_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              claim,
  input logic              push,
  input logic              pop,
  input logic              irq,
  input logic              win_vld,
  input logic [IW-1:0]     win_id,
  input logic [DW-1:0]     depth,
  input logic [PRIO_W-1:0] top_prio
);
  // R5
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> depth == DW'($past(depth) + 1'b1));

  // R8
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth != '0) |=> depth == DW'($past(depth) - 1'b1));

  // R6
  nest_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth != '0) |=> top_prio > $past(top_prio));

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(STK_DEPTH));

  // R7
  spur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !irq && !pop) |=> $stable(depth));

  // R11
  fast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> win_id != '0);
endmodule

bind vec_intc vec_intc_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .claim(claim_rd), .push(push), .pop(pop),
  .irq(irq_o), .win_vld(win_vld), .win_id(win_id),
  .depth(stk_depth), .top_prio(top_prio)
);

// File: tb/vec_intc_bench.sv
`timescale 1ns/1ps
module vec_intc_bench;
  localparam logic [9:0] A_CLAIM = 10'h100, A_FVEC = 10'h104, A_SPUR = 10'h108,
    A_EOI = 10'h10C, A_ENSET = 10'h110, A_ENCLR = 10'h114, A_PSET = 10'h118,
    A_PCLR = 10'h11C, A_FFSET = 10'h120, A_FFCLR = 10'h124, A_PEND = 10'h128,
    A_ENAB = 10'h12C, A_FFST = 10'h130, A_SERV = 10'h134;
  localparam logic [31:0] T_LLO = 32'h00, T_FALL = 32'h20, T_LHI = 32'h40, T_RISE = 32'h60;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] src;
  logic bus_wr, bus_rd;
  logic [9:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq, fiq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_intc u_vec_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic drive(input int i, input logic v);
    @(negedge clk);
    src[i] = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int i, input logic [31:0] trig, input int prio);
    wr(10'(i * 4), trig | 32'(prio));
    wr(10'(10'h080 + i * 4), 32'h1000 + 32'(i));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);
    rd(A_ENAB, d); chk("R1 enable set", d, 0);
    rd(A_FFST, d); chk("R1 fast set", d, 0);
    rd(A_SERV, d); chk("R1 servicing", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    cfg(3, T_LHI, 2);
    wr(A_ENSET, 32'h8);
    drive(3, 1'b1); settle();
    chk("R2 level-high raises irq", {31'b0, irq}, 1);
    wr(A_ENCLR, 32'h8); settle();
    chk("R4 disabled source masked", {31'b0, irq}, 0);
    wr(A_ENSET, 32'h8); settle();
    chk("R4 re-enabled source", {31'b0, irq}, 1);
    drive(3, 1'b0); settle();
    chk("R2 level released", {31'b0, irq}, 0);
    cfg(4, T_LLO, 1); settle();
    rd(A_PEND, d); chk("R2 level-low pending at 0", {31'b0, d[4]}, 1);
    drive(4, 1'b1); settle();
    rd(A_PEND, d); chk("R2 level-low idle at 1", {31'b0, d[4]}, 0);
  endtask

  task automatic t_spur();
    logic [31:0] d;
    wr(A_SPUR, 32'hDEAD);
    rd(A_CLAIM, d); chk("R7 spurious vector", d, 32'hDEAD);
    rd(A_SERV, d); chk("R7 stack unchanged", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    cfg(5, T_LHI, 3); cfg(9, T_LHI, 3); cfg(7, T_LHI, 1);
    wr(A_ENSET, 32'h2A0);
    drive(7, 1'b1); drive(9, 1'b1); drive(5, 1'b1); settle();
    chk("R4 irq with three pending", {31'b0, irq}, 1);
    rd(A_CLAIM, d); chk("R4 tie goes to lowest index", d, 32'h1005);
    settle();
    chk("R5 irq drops after claim", {31'b0, irq}, 0);
    rd(A_SERV, d); chk("R5 servicing id", d, 32'h8000_0005);
    rd(A_CLAIM, d); chk("R7 blocked claim spurious", d, 32'hDEAD);
    wr(A_EOI, 0); settle();
    chk("R8 irq back after eoi", {31'b0, irq}, 1);
    drive(5, 1'b0); settle();
    rd(A_CLAIM, d); chk("R4 next equal priority", d, 32'h1009);
    wr(A_EOI, 0);
    drive(9, 1'b0); settle();
    rd(A_CLAIM, d); chk("R4 lower priority last", d, 32'h1007);
    wr(A_EOI, 0);
    rd(A_SERV, d); chk("R8 stack empty", d, 0);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    settle();
    rd(A_CLAIM, d); chk("R6 base claim", d, 32'h1007);
    drive(9, 1'b1); settle();
    chk("R6 higher priority preempts", {31'b0, irq}, 1);
    rd(A_CLAIM, d); chk("R6 nested vector", d, 32'h1009);
    drive(9, 1'b0); wr(A_EOI, 0);
    rd(A_SERV, d); chk("R8 previous level exposed", d, 32'h8000_0007);
    settle();
    chk("R6 same level blocked", {31'b0, irq}, 0);
    wr(A_EOI, 0); settle();
    chk("R8 empty stack re-raises", {31'b0, irq}, 1);
    drive(7, 1'b0); settle();
    chk("R2 all released", {31'b0, irq}, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    cfg(12, T_RISE, 4); cfg(13, T_FALL, 4);
    drive(13, 1'b1);
    wr(A_ENSET, 32'h3000);
    drive(12, 1'b1); drive(12, 1'b0); settle();
    chk("R3 rising edge latched", {31'b0, irq}, 1);
    rd(A_CLAIM, d); chk("R3 edge vector", d, 32'h100C);
    wr(A_EOI, 0); settle();
    chk("R9 claim removed latched edge", {31'b0, irq}, 0);
    wr(A_PSET, 32'h1000); settle();
    chk("R10 pending-set", {31'b0, irq}, 1);
    wr(A_PCLR, 32'h1000); settle();
    chk("R10 pending-clear", {31'b0, irq}, 0);
    drive(13, 1'b0); settle();
    chk("R3 falling edge latched", {31'b0, irq}, 1);
    wr(A_PCLR, 32'h2000); settle();
    chk("R10 falling cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_fast();
    logic [31:0] d;
    cfg(0, T_LHI, 7);
    wr(A_ENSET, 32'h1);
    drive(0, 1'b1); settle();
    chk("R11 source 0 on fast line", {31'b0, fiq}, 1);
    chk("R11 source 0 not on normal", {31'b0, irq}, 0);
    rd(A_FVEC, d); chk("R11 fast vector", d, 32'h1000);
    drive(0, 1'b0); settle();
    cfg(20, T_LHI, 5);
    wr(A_ENSET, 32'h0010_0000); wr(A_FFSET, 32'h0010_0000);
    drive(20, 1'b1); settle();
    chk("R12 steered on fast", {31'b0, fiq}, 1);
    chk("R12 steered off normal", {31'b0, irq}, 0);
    rd(A_FFST, d); chk("R12 fast set readback", d, 32'h0010_0000);
    wr(A_FFCLR, 32'h0010_0000); settle();
    chk("R12 unsteered fast low", {31'b0, fiq}, 0);
    chk("R12 unsteered normal high", {31'b0, irq}, 1);
    drive(20, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_spur();
    t_prio();
    t_nest();
    t_edge();
    t_fast();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule